// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This block takes two floating-point bit patterns and returns one of them. Four selections are available: the signed minimum, the signed maximum, the operand of smaller magnitude, and the operand of larger magnitude. The result is always one of the two input patterns, bit for bit. It is never a computed value, so no rounding or arithmetic takes place.

The unit orders its operands by decoding the sign-magnitude bit patterns directly. NaN operands follow fixed selection rules that favour a numeric operand whenever one exists. The exponent and fraction widths are parameters; the defaults give IEEE-754 single precision. A caller presents both operands and an opcode with a valid strobe. The chosen pattern appears in a result register one clock later, and that register holds its value until the next strobe.

Top module: `fminmax_unit`

## Requirements
- R1: While `rst` is high, `out_valid` is 0 and `result` is all zeros at the following clock edge.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` changes only on a clock edge where `in_valid` was high, and otherwise it keeps its value.
- R3: An operand is NaN when its exponent field is all ones and its fraction is nonzero. If both operands are NaN, the result is `fs`.
- R4: If exactly one operand is NaN, the result is the other operand, for every opcode.
- R5: Opcode 0 (minimum): the result is `ft` when `fs` ≥ `ft` numerically, and `fs` otherwise.
- R6: Opcode 1 (maximum): the result is `ft` when `fs` ≤ `ft` numerically, and `fs` otherwise.
- R7: Opcode 2 (smaller magnitude): the result is the operand with the smaller absolute value.
- R8: Opcode 3 (larger magnitude): the result is the operand with the larger absolute value.
- R9: For opcodes 2 and 3, when the absolute values are equal, the result is `fs` if `fs` > `ft` numerically, and `ft` otherwise.
- R10: +0 and −0 compare as numerically equal. For every opcode, a pair made of the two zeros therefore yields `ft`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 2 | Selection: 0 min, 1 max, 2 min by magnitude, 3 max by magnitude |
| fs | input | EXP_W+MAN_W+1 | First operand bit pattern |
| ft | input | EXP_W+MAN_W+1 | Second operand bit pattern |
| out_valid | output | 1 | Result register loaded on the previous edge |
| result | output | EXP_W+MAN_W+1 | Selected operand pattern |

## Verification
The bench builds one instance with EXP_W=3 and MAN_W=2, giving 6-bit patterns. It sweeps every pair of operands under every opcode, 16384 cases in all. That sweep reaches every case: both zeros, subnormals, infinities, every NaN pairing, and every tie of equal magnitude. The expected result comes from decoding each pattern into a signed integer value in the bench. A second instance with the default single-precision widths gets directed checks on real values, to confirm that the field split scales.

// File: rtl/fminmax_pkg.sv
package fminmax_pkg;
  typedef enum logic [1:0] {
    SEL_MIN    = 2'd0,
    SEL_MAX    = 2'd1,
    SEL_MINMAG = 2'd2,
    SEL_MAXMAG = 2'd3
  } sel_op_e;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = EXP_W + MAN_W + 1
) (
  input  logic [W-1:0] bits,
  output logic         is_nan,
  output logic         is_zero,
  output logic         sgn,
  output logic [W-2:0] mag
);
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;
  assign expo    = bits[W-2 -: EXP_W];
  assign frac    = bits[MAN_W-1:0];
  assign sgn     = bits[W-1];
  assign mag     = bits[W-2:0];
  assign is_nan  = (&expo) && (|frac);
  assign is_zero = (mag == '0);
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
  parameter int MW = 31
) (
  input  logic          a_sgn,
  input  logic          b_sgn,
  input  logic [MW-1:0] a_mag,
  input  logic [MW-1:0] b_mag,
  input  logic          a_zero,
  input  logic          b_zero,
  output logic          a_lt,
  output logic          a_eq,
  output logic          mag_lt,
  output logic          mag_eq
);
  // magnitude order is plain unsigned order of exponent:fraction
  assign mag_lt = a_mag < b_mag;
  assign mag_eq = a_mag == b_mag;

  always_comb begin
    if (a_zero && b_zero) begin
      a_lt = 1'b0;
      a_eq = 1'b1;
    end else if (a_sgn != b_sgn) begin
      a_lt = a_sgn;
      a_eq = 1'b0;
    end else begin
      a_lt = a_sgn ? (a_mag > b_mag) : mag_lt;
      a_eq = mag_eq;
    end
  end
endmodule

// File: rtl/fmm_pick.sv
module fmm_pick
  import fminmax_pkg::*;
#(
  parameter int W = 32
) (
  input  sel_op_e      op,
  input  logic [W-1:0] fs,
  input  logic [W-1:0] ft,
  input  logic         fs_nan,
  input  logic         ft_nan,
  input  logic         lt,
  input  logic         eq,
  input  logic         mag_lt,
  input  logic         mag_eq,
  output logic [W-1:0] pick
);
  logic [W-1:0] tie_pick;
  assign tie_pick = (!lt && !eq) ? fs : ft;

  always_comb begin
    if (fs_nan) begin
      pick = ft_nan ? fs : ft;
    end else if (ft_nan) begin
      pick = fs;
    end else begin
      unique case (op)
        SEL_MIN:    pick = lt ? fs : ft;
        SEL_MAX:    pick = (lt || eq) ? ft : fs;
        SEL_MINMAG: pick = mag_lt ? fs : (mag_eq ? tie_pick : ft);
        SEL_MAXMAG: pick = mag_lt ? ft : (mag_eq ? tie_pick : fs);
        default:    pick = ft;
      endcase
    end
  end
endmodule

// File: rtl/fminmax_unit.sv
module fminmax_unit
  import fminmax_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = EXP_W + MAN_W + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   op,
  input  logic [W-1:0] fs,
  input  logic [W-1:0] ft,
  output logic         out_valid,
  output logic [W-1:0] result
);
  logic [W-1:0] opnd [2];
  logic [1:0]   nan_v, zero_v, sgn_v;
  logic [W-2:0] mag_v [2];

  assign opnd[0] = fs;
  assign opnd[1] = ft;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .bits   (opnd[i]),
      .is_nan (nan_v[i]),
      .is_zero(zero_v[i]),
      .sgn    (sgn_v[i]),
      .mag    (mag_v[i])
    );
  end

  logic lt, eq, mag_lt, mag_eq;
  fmm_order #(.MW(W-1)) u_ord (
    .a_sgn (sgn_v[0]),  .b_sgn (sgn_v[1]),
    .a_mag (mag_v[0]),  .b_mag (mag_v[1]),
    .a_zero(zero_v[0]), .b_zero(zero_v[1]),
    .a_lt  (lt),        .a_eq  (eq),
    .mag_lt(mag_lt),    .mag_eq(mag_eq)
  );

  logic [W-1:0] pick;
  fmm_pick #(.W(W)) u_pick (
    .op    (sel_op_e'(op)),
    .fs    (fs),       .ft    (ft),
    .fs_nan(nan_v[0]), .ft_nan(nan_v[1]),
    .lt    (lt),       .eq    (eq),
    .mag_lt(mag_lt),   .mag_eq(mag_eq),
    .pick  (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= pick;
    end
  end

  // R2: valid follows the strobe by one cycle
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_result_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // R3: two NaNs give the first operand
  assert_nan_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && nan_v[0] && nan_v[1]) |=> (result == $past(fs)));
  // R4: a single NaN yields the numeric operand
  assert_nan_fs_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && nan_v[0] && !nan_v[1]) |=> (result == $past(ft)));
  assert_nan_ft_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !nan_v[0] && nan_v[1]) |=> (result == $past(fs)));
  // R5: minimum never returns the strictly larger operand
  assert_min_order_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd0 && nan_v == 2'b00 && lt) |=> (result == $past(fs)));
  // R10: equal zeros of either sign give ft
  assert_zero_pair_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && zero_v == 2'b11) |=> (result == $past(ft)));
endmodule

// File: tb/sim_fminmax_unit.sv
module sim_fminmax_unit;
  localparam int SE = 3;
  localparam int SM = 2;
  localparam int SW = SE + SM + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          iv0 = 1'b0, iv1 = 1'b0;
  logic [1:0]    op0 = '0, op1 = '0;
  logic [SW-1:0] a0 = '0, b0 = '0;
  logic [31:0]   a1 = '0, b1 = '0;
  logic          ov0, ov1;
  logic [SW-1:0] r0;
  logic [31:0]   r1;

  int checks = 0;
  int fails  = 0;

  fminmax_unit #(.EXP_W(SE), .MAN_W(SM)) u0 (
    .clk(clk), .rst(rst), .in_valid(iv0), .op(op0), .fs(a0), .ft(b0),
    .out_valid(ov0), .result(r0));

  fminmax_unit u1 (
    .clk(clk), .rst(rst), .in_valid(iv1), .op(op1), .fs(a1), .ft(b1),
    .out_valid(ov1), .result(r1));

  function automatic bit is_nan(logic [SW-1:0] x);
    return (x[SW-2 -: SE] == '1) && (x[SM-1:0] != '0);
  endfunction

  // signed value scaled to an integer; infinity is far above any finite value
  function automatic int value(logic [SW-1:0] x);
    int e, m, mg;
    e = int'(x[SW-2 -: SE]);
    m = int'(x[SM-1:0]);
    if (e == (1 << SE) - 1) mg = 1 << 20;
    else if (e == 0)        mg = m;
    else                    mg = ((1 << SM) + m) << (e - 1);
    return x[SW-1] ? -mg : mg;
  endfunction

  function automatic int absv(int v);
    return v < 0 ? -v : v;
  endfunction

  function automatic logic [SW-1:0] model(int op, logic [SW-1:0] a, logic [SW-1:0] b);
    int va, vb;
    logic [SW-1:0] tie;
    if (is_nan(a) && is_nan(b)) return a;
    if (is_nan(a)) return b;
    if (is_nan(b)) return a;
    va = value(a); vb = value(b);
    tie = (va > vb) ? a : b;
    case (op)
      0: return (va >= vb) ? b : a;
      1: return (va <= vb) ? b : a;
      2: return (absv(va) < absv(vb)) ? a : (absv(va) > absv(vb)) ? b : tie;
      default: return (absv(va) > absv(vb)) ? a : (absv(va) < absv(vb)) ? b : tie;
    endcase
  endfunction

  function automatic string tag_of(int op, logic [SW-1:0] a, logic [SW-1:0] b);
    if (is_nan(a) && is_nan(b)) return "R3";
    if (is_nan(a) || is_nan(b)) return "R4";
    if (value(a) == 0 && value(b) == 0) return "R10";
    if (op >= 2 && absv(value(a)) == absv(value(b))) return "R9";
    case (op)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [SW-1:0] last0;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid", {31'd0, ov0}, 32'd0);
    check("R1 result", {26'd0, r0}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // exhaustive sweep of the small format
    for (int o = 0; o < 4; o++) begin
      for (int i = 0; i < (1 << SW); i++) begin
        for (int j = 0; j < (1 << SW); j++) begin
          @(negedge clk);
          iv0 = 1'b1; op0 = 2'(o); a0 = SW'(i); b0 = SW'(j);
          @(posedge clk);
          #1;
          last0 = model(o, SW'(i), SW'(j));
          check(tag_of(o, SW'(i), SW'(j)), {26'd0, r0}, {26'd0, last0});
          if (ov0 !== 1'b1) check("R2 out_valid high", {31'd0, ov0}, 32'd1);
        end
      end
    end

    // R2: no strobe, result holds and valid drops
    @(negedge clk);
    iv0 = 1'b0; op0 = 2'd1; a0 = 6'b011000; b0 = 6'b000001;
    @(posedge clk);
    #1;
    check("R2 valid low", {31'd0, ov0}, 32'd0);
    check("R2 result hold", {26'd0, r0}, {26'd0, last0});

    // single-precision directed cases on u1: 1.0 vs -2.0
    for (int o = 0; o < 4; o++) begin
      @(negedge clk);
      iv1 = 1'b1; op1 = 2'(o); a1 = 32'h3F80_0000; b1 = 32'hC000_0000;
      @(posedge clk);
      #1;
      case (o)
        0: check("R5 single", r1, 32'hC000_0000);
        1: check("R6 single", r1, 32'h3F80_0000);
        2: check("R7 single", r1, 32'h3F80_0000);
        default: check("R8 single", r1, 32'hC000_0000);
      endcase
    end
    @(negedge clk);
    op1 = 2'd0; a1 = 32'h7FC0_0000; b1 = 32'h3F80_0000;
    @(posedge clk); #1;
    check("R4 single", r1, 32'h3F80_0000);
    @(negedge clk);
    op1 = 2'd3; a1 = 32'hC040_0000; b1 = 32'h4040_0000;
    @(posedge clk); #1;
    check("R9 single", r1, 32'h4040_0000);
    @(negedge clk);
    op1 = 2'd1; a1 = 32'h8000_0000; b1 = 32'h0000_0000;
    @(posedge clk); #1;
    check("R10 single", r1, 32'h0000_0000);
    @(negedge clk);
    op1 = 2'd2; a1 = 32'h7F80_0001; b1 = 32'hFFC0_0000;
    @(posedge clk); #1;
    check("R3 single", r1, 32'h7F80_0001);
    @(negedge clk);
    iv1 = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule